// File: doc/BRIEF.md
# Redundant Three-Operand Floating-Point Adder

This block adds three floating-point terms X, Y and A in one step. Each significand is held in binary signed-digit form: digit i is a pair of bits, one positive-weighted and one negative-weighted, and its value is the positive bit minus the negative bit. Digit i of an operand has weight 2^(i+e), where e is that operand's exponent. Exponents are signed 8-bit two's-complement values with the bias already removed. Because every digit carries its own sign, the block has no sign-handling logic and no final carry-propagate adder. Its result is an un-normalized signed-digit significand together with the exponent of that result's lowest digit. Normalization, rounding and conversion back to binary belong to later stages.

The operation has two alignment steps. First the X and Y exponents are compared. The operand with the smaller exponent is shifted right by the difference inside a window that has four guard digits. A carry-limited signed-digit adder then forms a 29-digit partial sum. Next, A is pre-placed 30 digits to the left of that frame, plus the guard digits. It is shifted right by the bigger exponent minus A's exponent plus 30, which gives a 58-digit aligned term. A second signed-digit adder adds this term to the zero-extended partial sum. A single register stage holds the result, and a valid flag travels alongside it.

Top module: `redFp3Add`

## Requirements
- R1: `outValid` rises in the cycle after an input cycle with `inValid` high and is low after any cycle with `inValid` low. While `rstN` is low, `outValid` is 0 and `resPos`, `resNeg` and `resExp` are all zero.
- R2: After a valid input, the value sum over i of (resPos[i]-resNeg[i])·2^(i+resExp) equals X+Y+A under the alignment rules of R4 to R7. It is exact whenever no digit is shifted out.
- R3: `resExp` is a signed 9-bit value equal to max(xExp, yExp) - 4, the weight of result digit 0.
- R4: The operand with the smaller exponent is first placed with 4 guard digits below its lowest digit. It is then shifted right by the exponent difference. Its positive and negative bit vectors are shifted alike, and digits that fall below the guard window are dropped. When the exponents are equal, neither operand is shifted.
- R5: An exponent difference of 28 or more (significand plus guard digits) clears the smaller operand to all-zero digits.
- R6: A is pre-shifted left by 34 digit positions inside a 58-digit field. It is then shifted right by max(xExp,yExp) - aExp + 30, with digits below position 0 dropped. An offset of 58 or more clears A.
- R7: A negative A offset (aExp more than 30 above the bigger X/Y exponent) clears A.
- R8: No result digit has both its positive and its negative bit set.
- R9: After a cycle with `inValid` low, `resPos`, `resNeg` and `resExp` keep their previous values.
- R10: Negative significands, mixed-sign digits and digits with both bits set (value 0) are summed correctly through the digit encoding alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input operands valid this cycle |
| xExp | input | 8 | Exponent of X, signed |
| xPos | input | 24 | Positive bits of X significand |
| xNeg | input | 24 | Negative bits of X significand |
| yExp | input | 8 | Exponent of Y, signed |
| yPos | input | 24 | Positive bits of Y significand |
| yNeg | input | 24 | Negative bits of Y significand |
| aExp | input | 8 | Exponent of A, signed |
| aPos | input | 24 | Positive bits of A significand |
| aNeg | input | 24 | Negative bits of A significand |
| outValid | output | 1 | Result valid |
| resExp | output | 9 | Weight exponent of result digit 0, signed |
| resPos | output | 59 | Positive bits of result significand |
| resNeg | output | 59 | Negative bits of result significand |

## Verification
All datapath work is combinational ahead of one output register. Every result, along with its valid flag and exponent, is therefore due exactly one clock after the input cycle that produced it. The bench drives inputs on the falling edge. On the next falling edge it compares the outputs against a prediction that an integer model formed when those inputs were driven. After an idle input cycle, the same comparison expects `outValid` low and the result fields unchanged from the last valid result. Directed vectors are placed at the exact shift boundaries (difference 27 and 28, A offset -1, 0, 57 and 58), and random traffic with idle gaps follows them.

// File: rtl/fp3_pkg.sv
package fp3_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctlStrobes_t;
endpackage

// File: rtl/bsdAdder.sv
// Carry-limited signed-digit adder: each carry depends only on the digit
// pair at its own position and the one directly below it.
module bsdAdder #(
  parameter int D = 8
) (
  input  logic [D-1:0] aP,
  input  logic [D-1:0] aN,
  input  logic [D-1:0] bP,
  input  logic [D-1:0] bN,
  output logic [D:0]   sP,
  output logic [D:0]   sN
);
  always_comb begin
    int w, t, cCur, cNext, s;
    logic lowNonNeg;
    sP = '0;
    sN = '0;
    cCur = 0;
    lowNonNeg = 1'b1;
    for (int i = 0; i < D; i++) begin
      w = int'(aP[i]) - int'(aN[i]) + int'(bP[i]) - int'(bN[i]);
      case (w)
        2:       begin cNext = 1;  t = 0; end
        -2:      begin cNext = -1; t = 0; end
        1:       begin cNext = lowNonNeg ? 1 : 0;  t = lowNonNeg ? -1 : 1; end
        -1:      begin cNext = lowNonNeg ? 0 : -1; t = lowNonNeg ? -1 : 1; end
        default: begin cNext = 0;  t = 0; end
      endcase
      s = t + cCur;
      sP[i] = (s == 1);
      sN[i] = (s == -1);
      lowNonNeg = (w >= 0);
      cCur = cNext;
    end
    sP[D] = (cCur == 1);
    sN[D] = (cCur == -1);
  end
endmodule

// File: rtl/fp3Ctrl.sv
module fp3Ctrl
  import fp3_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctlStrobes_t strobes,
  output logic        outValid
);
  always_comb strobes.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fp3Datapath.sv
module fp3Datapath
  import fp3_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int SIG_D = 24,
  parameter int GRD_D = 4,
  parameter int PRE_D = 30
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctlStrobes_t                     strobes,
  input  logic [EXP_W-1:0]                xExp,
  input  logic [SIG_D-1:0]                xPos,
  input  logic [SIG_D-1:0]                xNeg,
  input  logic [EXP_W-1:0]                yExp,
  input  logic [SIG_D-1:0]                yPos,
  input  logic [SIG_D-1:0]                yNeg,
  input  logic [EXP_W-1:0]                aExp,
  input  logic [SIG_D-1:0]                aPos,
  input  logic [SIG_D-1:0]                aNeg,
  output logic [EXP_W:0]                  resExp,
  output logic [SIG_D+PRE_D+GRD_D:0]      resPos,
  output logic [SIG_D+PRE_D+GRD_D:0]      resNeg
);
  localparam int ALN_D  = SIG_D + GRD_D;
  localparam int SUM_D  = ALN_D + 1;
  localparam int WIDE_D = SIG_D + PRE_D + GRD_D;
  localparam int RES_D  = WIDE_D + 1;

  // ---- first alignment: X against Y ----
  logic signed [EXP_W:0] xExpX, yExpX;
  logic                  xIsBig;
  logic [EXP_W:0]        diff;
  logic [EXP_W-1:0]      eBig;
  logic [ALN_D-1:0]      xExtP, xExtN, yExtP, yExtN;
  logic [ALN_D-1:0]      bigP, bigN, smallP, smallN, smallShP, smallShN;

  assign xExpX  = {xExp[EXP_W-1], xExp};
  assign yExpX  = {yExp[EXP_W-1], yExp};
  assign xIsBig = (xExpX >= yExpX);
  assign diff   = xIsBig ? xExpX - yExpX : yExpX - xExpX;
  assign eBig   = xIsBig ? xExp : yExp;

  assign xExtP = {xPos, {GRD_D{1'b0}}};
  assign xExtN = {xNeg, {GRD_D{1'b0}}};
  assign yExtP = {yPos, {GRD_D{1'b0}}};
  assign yExtN = {yNeg, {GRD_D{1'b0}}};

  assign bigP   = xIsBig ? xExtP : yExtP;
  assign bigN   = xIsBig ? xExtN : yExtN;
  assign smallP = xIsBig ? yExtP : xExtP;
  assign smallN = xIsBig ? yExtN : xExtN;

  assign smallShP = (diff >= (EXP_W+1)'(ALN_D)) ? '0 : smallP >> diff;
  assign smallShN = (diff >= (EXP_W+1)'(ALN_D)) ? '0 : smallN >> diff;

  logic [SUM_D-1:0] sumP, sumN;

  bsdAdder #(.D(ALN_D)) u_addXY (
    .aP(bigP), .aN(bigN), .bP(smallShP), .bN(smallShN),
    .sP(sumP), .sN(sumN)
  );

  // ---- second alignment: A against the partial sum ----
  logic [EXP_W+1:0]  aOff;
  logic              aDrop;
  logic [WIDE_D-1:0] aExtP, aExtN, aShP, aShN, sumWideP, sumWideN;

  assign aOff  = {{2{eBig[EXP_W-1]}}, eBig} - {{2{aExp[EXP_W-1]}}, aExp}
               + (EXP_W+2)'(PRE_D);
  assign aDrop = aOff[EXP_W+1] || (aOff >= (EXP_W+2)'(WIDE_D));

  assign aExtP = {aPos, {(PRE_D+GRD_D){1'b0}}};
  assign aExtN = {aNeg, {(PRE_D+GRD_D){1'b0}}};
  assign aShP  = aDrop ? '0 : aExtP >> aOff;
  assign aShN  = aDrop ? '0 : aExtN >> aOff;

  assign sumWideP = {{(WIDE_D-SUM_D){1'b0}}, sumP};
  assign sumWideN = {{(WIDE_D-SUM_D){1'b0}}, sumN};

  logic [RES_D-1:0] totP, totN;

  bsdAdder #(.D(WIDE_D)) u_addA (
    .aP(aShP), .aN(aShN), .bP(sumWideP), .bN(sumWideN),
    .sP(totP), .sN(totN)
  );

  // ---- output register ----
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resExp <= '0;
      resPos <= '0;
      resNeg <= '0;
    end else if (strobes.capture) begin
      resExp <= {eBig[EXP_W-1], eBig} - (EXP_W+1)'(GRD_D);
      resPos <= totP;
      resNeg <= totN;
    end
  end
endmodule

// File: rtl/redFp3Add.sv
module redFp3Add
  import fp3_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int SIG_D = 24,
  parameter int GRD_D = 4,
  parameter int PRE_D = 30
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [EXP_W-1:0]           xExp,
  input  logic [SIG_D-1:0]           xPos,
  input  logic [SIG_D-1:0]           xNeg,
  input  logic [EXP_W-1:0]           yExp,
  input  logic [SIG_D-1:0]           yPos,
  input  logic [SIG_D-1:0]           yNeg,
  input  logic [EXP_W-1:0]           aExp,
  input  logic [SIG_D-1:0]           aPos,
  input  logic [SIG_D-1:0]           aNeg,
  output logic                       outValid,
  output logic [EXP_W:0]             resExp,
  output logic [SIG_D+PRE_D+GRD_D:0] resPos,
  output logic [SIG_D+PRE_D+GRD_D:0] resNeg
);
  ctlStrobes_t strobes;

  fp3Ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  fp3Datapath #(.EXP_W(EXP_W), .SIG_D(SIG_D), .GRD_D(GRD_D), .PRE_D(PRE_D)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .xExp(xExp), .xPos(xPos), .xNeg(xNeg),
    .yExp(yExp), .yPos(yPos), .yNeg(yNeg),
    .aExp(aExp), .aPos(aPos), .aNeg(aNeg),
    .resExp(resExp), .resPos(resPos), .resNeg(resNeg)
  );
endmodule

// File: rtl/redFp3Add_chk.sv
module redFp3Add_chk #(
  parameter int EXP_W = 8,
  parameter int SIG_D = 24,
  parameter int GRD_D = 4,
  parameter int PRE_D = 30
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic [EXP_W-1:0]           xExp,
  input logic [EXP_W-1:0]           yExp,
  input logic                       outValid,
  input logic [EXP_W:0]             resExp,
  input logic [SIG_D+PRE_D+GRD_D:0] resPos,
  input logic [SIG_D+PRE_D+GRD_D:0] resNeg
);
  logic signed [EXP_W:0] xS, yS, bigExp;
  assign xS     = {xExp[EXP_W-1], xExp};
  assign yS     = {yExp[EXP_W-1], yExp};
  assign bigExp = (xS >= yS) ? xS : yS;

  // R1: valid follows input valid by one cycle
  assert_valid_lag_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_lag_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3: result exponent is the bigger input exponent minus the guard digits
  assert_exp_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resExp == $past(bigExp) - (EXP_W+1)'(GRD_D));

  // R8: canonical digits only
  assert_canon_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (resPos & resNeg) == '0);

  // R9: result fields hold across idle cycles
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(resPos) && $stable(resNeg) && $stable(resExp));
endmodule

bind redFp3Add redFp3Add_chk #(.EXP_W(EXP_W), .SIG_D(SIG_D), .GRD_D(GRD_D), .PRE_D(PRE_D)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .xExp(xExp), .yExp(yExp),
  .outValid(outValid), .resExp(resExp), .resPos(resPos), .resNeg(resNeg)
);

// File: tb/redFp3Add_tb.sv
module redFp3Add_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [7:0]  xExp, yExp, aExp;
  logic [23:0] xPos, xNeg, yPos, yNeg, aPos, aNeg;
  logic        outValid;
  logic [8:0]  resExp;
  logic [58:0] resPos, resNeg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state: what the outputs must show at the next check
  bit      expV = 0;
  longint  expVal = 0;
  int      expE = 0;
  string   expTag = "R1";
  logic [58:0] holdP = '0, holdN = '0;
  logic [8:0]  holdE = '0;

  always #10 clk = ~clk;

  redFp3Add u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .xExp(xExp), .xPos(xPos), .xNeg(xNeg),
    .yExp(yExp), .yPos(yPos), .yNeg(yNeg),
    .aExp(aExp), .aPos(aPos), .aNeg(aNeg),
    .outValid(outValid), .resExp(resExp), .resPos(resPos), .resNeg(resNeg)
  );

  function automatic longint shr(longint v, int n);
    if (n >= 63) return 0;
    return v >>> n;
  endfunction

  function automatic longint refVal(int ex, int ey, int ea,
      logic [23:0] xp, logic [23:0] xn, logic [23:0] yp, logic [23:0] yn,
      logic [23:0] ap, logic [23:0] an);
    int eb = (ex >= ey) ? ex : ey;
    int s  = eb - ea + 30;
    longint sx = shr(longint'(xp) << 4, eb - ex) - shr(longint'(xn) << 4, eb - ex);
    longint sy = shr(longint'(yp) << 4, eb - ey) - shr(longint'(yn) << 4, eb - ey);
    longint sa = (s < 0) ? 0 : shr(longint'(ap) << 34, s) - shr(longint'(an) << 34, s);
    return sx + sy + sa;
  endfunction

  task automatic chk(bit ok, string msg, longint act, longint exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exv);
    end
  endtask

  task automatic checkOut();
    longint got = longint'(resPos) - longint'(resNeg);
    if (expV) begin
      chk(outValid == 1'b1, {"R1 outValid after valid/", expTag}, longint'(outValid), 1);
      chk(got == expVal, {"R2 value/", expTag}, got, expVal);
      chk(int'($signed(resExp)) == expE, {"R3 exponent/", expTag},
          longint'(int'($signed(resExp))), longint'(expE));
      chk((resPos & resNeg) == '0, "R8 canonical digits",
          longint'($countones(resPos & resNeg)), 0);
      holdP = resPos; holdN = resNeg; holdE = resExp;
    end else begin
      chk(outValid == 1'b0, "R1 outValid after idle", longint'(outValid), 0);
      chk(resPos == holdP && resNeg == holdN && resExp == holdE, "R9 hold while idle",
          got, longint'(holdP) - longint'(holdN));
    end
  endtask

  task automatic cyc(bit v, int ex, logic [23:0] xp, logic [23:0] xn,
                     int ey, logic [23:0] yp, logic [23:0] yn,
                     int ea, logic [23:0] ap, logic [23:0] an, string tag);
    @(negedge clk);
    checkOut();
    inValid = v;
    xExp = 8'(ex); xPos = xp; xNeg = xn;
    yExp = 8'(ey); yPos = yp; yNeg = yn;
    aExp = 8'(ea); aPos = ap; aNeg = an;
    expV = v;
    if (v) begin
      expVal = refVal(ex, ey, ea, xp, xn, yp, yn, ap, an);
      expE   = ((ex >= ey) ? ex : ey) - 4;
      expTag = tag;
    end
  endtask

  task automatic idle();
    cyc(0, 0, '0, '0, 0, '0, '0, 0, '0, '0, "R9");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0;
    xExp = '0; yExp = '0; aExp = '0;
    xPos = '0; xNeg = '0; yPos = '0; yNeg = '0; aPos = '0; aNeg = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0 && resPos == '0 && resNeg == '0 && resExp == '0,
        "R1 reset state", longint'(resPos), 0);
    rstN = 1'b1;

    idle();
    cyc(1, 0, 24'h0000F0, '0, 0, 24'h000003, '0, 0, 24'h000001, '0, "R2");
    cyc(1, 2, '0, 24'h001234, 2, 24'h000055, 24'h000F00, -5, 24'h00A0A0, 24'h050505, "R10");
    cyc(1, 10, 24'h123456, '0, 5, 24'hFFFFFF, '0, 0, 24'h000010, '0, "R4");
    cyc(1, 12, 24'h000101, '0, 20, 24'h00FF00, 24'h0000FF, 20, '0, 24'h000003, "R4");
    cyc(1, 3, 24'h000777, '0, -24, 24'hFFFFFF, 24'h00F0F0, 3, '0, '0, "R4");
    cyc(1, 3, 24'h000777, '0, -25, 24'hFFFFFF, 24'h00F0F0, 3, '0, '0, "R5");
    cyc(1, 127, 24'h800001, '0, -128, 24'hFFFFFF, '0, 100, 24'h000001, '0, "R5");
    idle();
    idle();
    cyc(1, 0, 24'h000001, '0, 0, '0, '0, -27, 24'hFFFFFF, 24'h000001, "R6");
    cyc(1, 0, 24'h000001, '0, 0, '0, '0, -28, 24'hFFFFFF, '0, "R6");
    cyc(1, 0, 24'h000002, '0, -1, '0, '0, 31, 24'h800000, '0, "R7");
    cyc(1, 0, 24'h000002, '0, -1, '0, '0, 30, 24'h800000, '0, "R6");
    cyc(1, -7, 24'hFFFFFF, 24'hFFFFFF, -7, 24'hAAAAAA, 24'h555555, -7, 24'hF0F0F0, 24'hFFFF00, "R10");
    cyc(1, -128, '0, 24'hFFFFFF, -128, '0, 24'hFFFFFF, 127, '0, 24'hFFFFFF, "R7");

    for (int k = 0; k < 600; k++) begin
      int base = int'($urandom_range(120)) - 60;
      if ($urandom_range(3) == 0) idle();
      cyc(1, base + int'($urandom_range(70)) - 35, 24'($urandom), 24'($urandom),
             base + int'($urandom_range(70)) - 35, 24'($urandom), 24'($urandom),
             base + int'($urandom_range(80)) - 50, 24'($urandom), 24'($urandom), "R2");
    end
    idle();
    idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule